// File: doc/BRIEF.md
# Packet-aware Color Depth Adapter

This block sits between two AXI4-Stream video links whose per-color-sample widths differ. Each beat carries `NUM_PLANES` color samples packed from the least significant end. In pixel beats of video packets, every sample is widened by appending zero bits below it, or narrowed by dropping its low bits and keeping the high ones. Every other beat is forwarded unchanged. The first beat of a packet is a header naming the packet kind. Metadata and other packet kinds pass through untouched.

The one exception is the image-information packet. It carries a field giving how many bits of each color plane are in use. When the adapter narrows, a field value above the output sample width is replaced. The replacement is a runtime value from a small register set, or the output width itself when no override is enabled. Register writes apply from the next packet header onward, never partway through a packet. The datapath is one register stage plus a one-entry skid buffer, so the input ready depends only on registered state.

Top module: `color_depth_adapter`

## Requirements
- R1: After reset, `m_tvalid` is 0, `s_tready` is 1, register 0x0 reads 0 and register 0x4 reads `OUT_BPS`.
- R2: The low nibble of a packet's first beat is its kind: 0 is video, 1 is image information, any other value is another kind. The kind holds until the beat with `s_tlast`, and the first beat itself is forwarded unmodified.
- R3: When `IN_BPS > OUT_BPS`, each sample p of a video-packet pixel beat (input bits `[p*IN_BPS +: IN_BPS]`) leaves as its top `OUT_BPS` bits at output bits `[p*OUT_BPS +: OUT_BPS]`.
- R4: When `IN_BPS < OUT_BPS`, each such sample leaves with `OUT_BPS-IN_BPS` zero bits appended below it. Output bits above `NUM_PLANES*OUT_BPS` are zero.
- R5: Beats of non-video packets, and header beats, leave bit-for-bit, zero-extended or truncated to the output bus width. The one field rewrite of R6 is the only exception.
- R6: When narrowing, if bits [4:0] of the second beat of an image-information packet exceed `OUT_BPS`, they are replaced. The replacement is the packet's latched override value when override is enabled, and `OUT_BPS` otherwise. A value at or below `OUT_BPS` is left unchanged.
- R7: When widening, the active-bits field is never modified.
- R8: Register 0x0 bit 0 enables the override, and register 0x4 bits [4:0] hold the override value. Both read back through `cfg_rdata`. Writes to any other offset change neither register.
- R9: The register values are sampled when a packet's first beat is accepted, so writes made during a packet do not affect that packet.
- R10: A beat accepted at a clock edge appears on the output after that same edge when the output stage is free. Beats are never lost, duplicated or reordered under backpressure.
- R11: While `m_tvalid` is high and `m_tready` is low, all output signals hold. `s_tready` falls only when a beat is parked in the skid buffer.
- R12: `m_tlast` and `m_tuser` travel with the data beat they arrived with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both streams and registers |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | IN_W | Input beat, samples packed from LSB |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Adapter can accept a beat |
| s_tlast | input | 1 | Last beat of input packet |
| s_tuser | input | 1 | Sideband flag carried with the beat |
| m_tdata | output | OUT_W | Output beat |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts the beat |
| m_tlast | output | 1 | Last beat of output packet |
| m_tuser | output | 1 | Sideband flag of the output beat |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register byte offset for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |

## Verification
Random packet streams mix video, image-information and unknown kinds, with lengths from one to six beats and active-bits fields at, below and above the output width. They run first with free flow, then under downstream stalls, then with input gaps and register writes arriving mid-packet. The free-flow run separates pixel conversion from passthrough. The stall runs expose skid-buffer loss, duplication or drift of data, last and user. The write traffic distinguishes per-packet latching from immediate use. A second instance configured for widening receives a few directed beats. Those beats check the zero padding, the untouched field and the one-cycle latency.

// File: rtl/color_depth_adapter.sv
module color_depth_adapter #(
  parameter int NUM_PLANES = 3,
  parameter int IN_BPS     = 10,
  parameter int OUT_BPS    = 8,
  parameter int ADDR_W     = 4,
  localparam int IN_W      = ((NUM_PLANES * IN_BPS + 7) / 8) * 8,
  localparam int OUT_W     = ((NUM_PLANES * OUT_BPS + 7) / 8) * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IN_W-1:0]   s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic              s_tlast,
  input  logic              s_tuser,
  output logic [OUT_W-1:0]  m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast,
  output logic              m_tuser,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata
);
  localparam int PIX_OUT = NUM_PLANES * OUT_BPS;
  localparam logic [4:0] OUT_FIELD = 5'(OUT_BPS);
  localparam bit NARROW = IN_BPS > OUT_BPS;

  logic             skid_v, skid_l, skid_u;
  logic [OUT_W-1:0] skid_d;
  logic [1:0]       beat;
  logic [3:0]       ptype;
  logic             reg_en, pkt_en;
  logic [4:0]       reg_val, pkt_val;
  logic [OUT_W-1:0] raw, pix, xf;
  logic             accept, out_free, fix;
  logic [4:0]       field;

  assign s_tready = ~skid_v;
  assign accept   = s_tvalid & s_tready;
  assign out_free = ~m_tvalid | m_tready;
  assign raw      = OUT_W'(s_tdata);

  genvar p;
  generate
    for (p = 0; p < NUM_PLANES; p++) begin : g_plane
      logic [IN_BPS+OUT_BPS-1:0] ext;
      assign ext = {s_tdata[p*IN_BPS +: IN_BPS], {OUT_BPS{1'b0}}};
      assign pix[p*OUT_BPS +: OUT_BPS] = ext[IN_BPS+OUT_BPS-1 -: OUT_BPS];
    end
    if (OUT_W > PIX_OUT) begin : g_fill
      assign pix[OUT_W-1:PIX_OUT] = '0;
    end
  endgenerate

  assign field = pkt_en ? pkt_val : OUT_FIELD;
  assign fix   = NARROW && beat == 2'd1 && ptype == 4'd1 && raw[4:0] > OUT_FIELD;

  always_comb begin
    if (beat == 2'd0)       xf = raw;
    else if (ptype == 4'd0) xf = pix;
    else if (fix)           xf = {raw[OUT_W-1:5], field};
    else                    xf = raw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_tvalid <= 1'b0;
      m_tdata  <= '0;
      m_tlast  <= 1'b0;
      m_tuser  <= 1'b0;
      skid_v   <= 1'b0;
      skid_d   <= '0;
      skid_l   <= 1'b0;
      skid_u   <= 1'b0;
    end else if (out_free) begin
      if (skid_v) begin
        m_tvalid <= 1'b1;
        m_tdata  <= skid_d;
        m_tlast  <= skid_l;
        m_tuser  <= skid_u;
        skid_v   <= 1'b0;
      end else begin
        m_tvalid <= accept;
        if (accept) begin
          m_tdata <= xf;
          m_tlast <= s_tlast;
          m_tuser <= s_tuser;
        end
      end
    end else if (accept) begin
      skid_v <= 1'b1;
      skid_d <= xf;
      skid_l <= s_tlast;
      skid_u <= s_tuser;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat    <= 2'd0;
      ptype   <= 4'd0;
      pkt_en  <= 1'b0;
      pkt_val <= OUT_FIELD;
    end else if (accept) begin
      if (beat == 2'd0) begin
        ptype   <= s_tdata[3:0];
        pkt_en  <= reg_en;
        pkt_val <= reg_val;
      end
      if (s_tlast)            beat <= 2'd0;
      else if (beat != 2'd2)  beat <= beat + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_en  <= 1'b0;
      reg_val <= OUT_FIELD;
    end else if (cfg_wr) begin
      if (cfg_addr == ADDR_W'(0)) reg_en  <= cfg_wdata[0];
      if (cfg_addr == ADDR_W'(4)) reg_val <= cfg_wdata[4:0];
    end
  end

  always_comb begin
    if (cfg_addr == ADDR_W'(0))      cfg_rdata = {31'd0, reg_en};
    else if (cfg_addr == ADDR_W'(4)) cfg_rdata = {27'd0, reg_val};
    else                             cfg_rdata = 32'd0;
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tuser));

  assert_skid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !s_tready |-> m_tvalid);

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> m_tvalid);

  assert_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && beat == 2'd1 && ptype == 4'd1 && s_tdata[4:0] <= OUT_FIELD |-> xf[4:0] == s_tdata[4:0]);

  assert_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && s_tlast |=> beat == 2'd0);

  assert_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    beat != 2'd0 |=> $stable(pkt_en) && $stable(pkt_val));
endmodule

// File: tb/tb_color_depth_adapter.sv
module tb_color_depth_adapter;
  localparam int NP = 3, IB = 10, OB = 8, IW = 32, OW = 24;
  localparam int WIB = 6, WOB = 8, WIW = 24, WOW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [IW-1:0] s_tdata = '0;
  logic s_tvalid = 1'b0, s_tlast = 1'b0, s_tuser = 1'b0, s_tready;
  logic [OW-1:0] m_tdata;
  logic m_tvalid, m_tlast, m_tuser, m_tready = 1'b0;
  logic cfg_wr = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;

  logic [WIW-1:0] w_sd = '0;
  logic w_sv = 1'b0, w_sl = 1'b0, w_su = 1'b0, w_sr;
  logic [WOW-1:0] w_md;
  logic w_mv, w_ml, w_mu;
  logic [31:0] w_rd;

  color_depth_adapter #(.NUM_PLANES(NP), .IN_BPS(IB), .OUT_BPS(OB)) dut (
    .clk, .rst_n, .s_tdata, .s_tvalid, .s_tready, .s_tlast, .s_tuser,
    .m_tdata, .m_tvalid, .m_tready, .m_tlast, .m_tuser,
    .cfg_wr, .cfg_addr, .cfg_wdata, .cfg_rdata);

  color_depth_adapter #(.NUM_PLANES(NP), .IN_BPS(WIB), .OUT_BPS(WOB)) dut_w (
    .clk, .rst_n, .s_tdata(w_sd), .s_tvalid(w_sv), .s_tready(w_sr), .s_tlast(w_sl),
    .s_tuser(w_su), .m_tdata(w_md), .m_tvalid(w_mv), .m_tready(1'b1), .m_tlast(w_ml),
    .m_tuser(w_mu), .cfg_wr(1'b0), .cfg_addr(4'd0), .cfg_wdata(32'd0), .cfg_rdata(w_rd));

  int n_checks = 0, n_fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic done();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired");
    done();
  end

  function automatic logic [31:0] model(input logic [31:0] d, input int idx, input int ty,
      input int ib, input int ob, input int ow, input bit en, input logic [4:0] val);
    logic [31:0] r, s;
    r = (ow >= 32) ? d : d & ((32'd1 << ow) - 1);
    if (idx > 0 && ty == 0) begin
      r = 0;
      for (int p = 0; p < NP; p++) begin
        s = (d >> (p * ib)) & ((32'd1 << ib) - 1);
        if (ib > ob) s = s >> (ib - ob);
        else s = s << (ob - ib);
        r = r | (s << (p * ob));
      end
    end else if (idx == 1 && ty == 1 && ib > ob && r[4:0] > ob) begin
      r[4:0] = en ? val : 5'(ob);
    end
    return r;
  endfunction

  logic [31:0] in_d[$];
  bit in_l[$], in_u[$];
  logic [31:0] e_d[$];
  bit e_l[$], e_u[$];
  string e_t[$];

  int m_idx = 0, m_ty = 0;
  bit m_en = 0, sh_en = 0;
  logic [4:0] m_val = 5'(OB), sh_val = 5'(OB);
  int gap = 0, bp = 0, wp = 0;
  bit in_acc = 0, prev_stall = 0;
  logic [OW-1:0] prev_d;
  bit prev_l, prev_u;

  task automatic add_packet(input int ty, input int len, input int info);
    for (int i = 0; i < len; i++) begin
      logic [31:0] d;
      d = $urandom;
      if (i == 0) d[3:0] = 4'(ty);
      if (i == 1 && ty == 1) d[4:0] = 5'(info);
      in_d.push_back(d);
      in_l.push_back(i == len - 1);
      in_u.push_back(($urandom % 2) == 1);
    end
  endtask

  task automatic step(input bit wr, input logic [3:0] addr, input logic [31:0] wd);
    bit in_hs, out_hs;
    @(negedge clk);
    if (!(s_tvalid && !in_acc)) begin
      s_tvalid = 1'b0;
      if (in_d.size() > 0 && ($urandom % 100) >= gap) begin
        s_tvalid = 1'b1;
        s_tdata = in_d[0];
        s_tlast = in_l[0];
        s_tuser = in_u[0];
      end
    end
    m_tready = ($urandom % 100) >= bp;
    cfg_wr = wr;
    if (wr) begin cfg_addr = addr; cfg_wdata = wd; end
    #1;
    in_hs = s_tvalid && s_tready;
    out_hs = m_tvalid && m_tready;
    if (prev_stall)
      chk(m_tvalid && m_tdata == prev_d && m_tlast == prev_l && m_tuser == prev_u,
          "R11 hold under stall", {8'd0, m_tdata}, {8'd0, prev_d});
    if (out_hs) begin
      if (e_d.size() == 0) chk(0, "R10 unexpected beat", {8'd0, m_tdata}, 0);
      else begin
        logic [31:0] ed; bit el, eu; string et;
        ed = e_d.pop_front(); el = e_l.pop_front(); eu = e_u.pop_front(); et = e_t.pop_front();
        chk({8'd0, m_tdata} == ed, et, {8'd0, m_tdata}, ed);
        chk(m_tlast == el && m_tuser == eu, "R12 last/user", {30'd0, m_tlast, m_tuser}, {30'd0, el, eu});
      end
    end
    if (in_hs) begin
      string tag;
      if (m_idx == 0) begin
        m_ty = int'(s_tdata[3:0]); m_en = sh_en; m_val = sh_val;
      end
      if (m_idx == 0) tag = "R2 header";
      else if (m_ty == 0) tag = "R3 pixel narrow";
      else if (m_ty == 1 && m_idx == 1) tag = m_en ? "R9 field latched" : "R6 field";
      else tag = "R5 passthrough";
      e_d.push_back(model(s_tdata, m_idx, m_ty, IB, OB, OW, m_en, m_val));
      e_l.push_back(s_tlast); e_u.push_back(s_tuser); e_t.push_back(tag);
      m_idx = s_tlast ? 0 : m_idx + 1;
      void'(in_d.pop_front()); void'(in_l.pop_front()); void'(in_u.pop_front());
    end
    in_acc = in_hs;
    if (wr) begin
      if (addr == 4'd0) sh_en = wd[0];
      if (addr == 4'd4) sh_val = wd[4:0];
    end
    prev_stall = m_tvalid && !m_tready;
    prev_d = m_tdata; prev_l = m_tlast; prev_u = m_tuser;
  endtask

  task automatic rstep();
    bit wr;
    logic [3:0] a;
    wr = ($urandom % 100) < wp;
    a = 4'(($urandom % 3) * 4);
    step(wr, a, $urandom % 32);
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && (in_d.size() > 0 || e_d.size() > 0); i++) rstep();
    chk(e_d.size() == 0 && in_d.size() == 0, "R10 all beats delivered", e_d.size(), 0);
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_addr = a;
    #1 chk(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  task automatic random_packets(input int n);
    int kinds[5] = '{0, 1, 2, 7, 15};
    int infos[6] = '{0, 5, 8, 9, 10, 31};
    for (int i = 0; i < n; i++)
      add_packet(kinds[$urandom % 5], 1 + ($urandom % 6), infos[$urandom % 6]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(m_tvalid == 1'b0, "R1 m_tvalid after reset", m_tvalid, 0);
    chk(s_tready == 1'b1, "R1 s_tready after reset", s_tready, 1);
    rd_check(4'd0, 32'd0, "R1 enable reset");
    rd_check(4'd4, 32'(OB), "R1 value reset");

    step(1, 4'd0, 32'h1); step(1, 4'd4, 32'hFFFF_FFED);
    rd_check(4'd0, 32'd1, "R8 enable readback");
    rd_check(4'd4, 32'd13, "R8 value readback");
    step(1, 4'd8, 32'h0);
    rd_check(4'd0, 32'd1, "R8 unmapped write ignored (enable)");
    rd_check(4'd4, 32'd13, "R8 unmapped write ignored (value)");
    step(1, 4'd0, 32'h0); step(1, 4'd4, 32'(OB));

    // R3 R5 R6: free flow
    random_packets(30); drain();
    // R11: downstream stalls
    bp = 45; random_packets(30); drain();
    // R9: gaps and register writes during packets
    gap = 30; bp = 30; wp = 8; random_packets(40); drain();

    // R9 directed: override 6 then change to 7 mid-packet
    gap = 0; bp = 0; wp = 0;
    step(1, 4'd0, 32'h1); step(1, 4'd4, 32'd6);
    add_packet(1, 3, 12);
    for (int i = 0; i < 20 && m_idx == 0; i++) step(0, 4'd0, 0);
    step(1, 4'd4, 32'd7);
    add_packet(1, 2, 20);
    drain();

    // R4 R7 R10: widening instance, directed
    begin
      logic [31:0] wd[6] = '{32'h00AB_CD10, 32'h00FF_FFFF, 32'h0012_3456, 32'h0055_AA01, 32'h00C3_5A1F, 32'h0000_0009};
      int widx[6] = '{0, 1, 2, 0, 1, 2};
      int wty[6]  = '{0, 0, 0, 1, 1, 1};
      bit wl[6]   = '{0, 0, 1, 0, 0, 1};
      string wt[6] = '{"R5 wide header", "R4 pixel widen", "R4 pixel widen", "R5 wide header", "R7 field kept", "R5 wide passthrough"};
      for (int i = 0; i <= 6; i++) begin
        @(negedge clk);
        if (i > 0) begin
          logic [31:0] ex;
          ex = model(wd[i-1], widx[i-1], wty[i-1], WIB, WOB, WOW, 0, 5'd0);
          chk(w_mv == 1'b1, "R10 one-cycle latency", w_mv, 1);
          chk({8'd0, w_md} == ex, wt[i-1], {8'd0, w_md}, ex);
          chk(w_ml == wl[i-1], "R12 wide last", w_ml, wl[i-1]);
        end
        if (i < 6) begin
          w_sv = 1'b1; w_sd = wd[i][WIW-1:0]; w_sl = wl[i]; w_su = 1'b0;
        end else w_sv = 1'b0;
      end
    end
    done();
  end
endmodule